// File: doc/BRIEF.md
# TDM frame timeslot mapper

The block follows a time-division multiplexed serial frame bit by bit and reports which kind of traffic the current bit carries. A bit clock input, oversampled by the block clock, advances a bit counter on one chosen edge. A frame-sync input of selectable polarity realigns the counter to a programmed offset. The counter wraps after a programmed frame length. An optional framing bit can occupy count 0. The remaining bits are grouped into 8-bit timeslots.

Each timeslot has a 2-bit channel type in a lookup table. The table is written as 32-bit words through a simple register write port. The type selects one of four qualifier outputs: packetized, 7-bit voice, 8-bit voice or unassigned. The block also steers the transmit pin. Unassigned slots, and the one unused bit of a 7-bit voice slot, can be driven low, driven high or left floating. Table writes go to a shadow copy, which becomes active only at a frame boundary, so no frame is decoded from a mixed table.

Top module: `tdm_slot_mapper`

## Requirements
- R1: After reset the counter is 0, all control fields are 0, the frame length is MAX_SLOTS*8 bits, the offset is 0 and the active table is all unassigned. The outputs therefore show slot 0, bit 0, unassigned, driven low.
- R2: The counter advances by one on each sampling edge of bclk_i and holds otherwise. The sampling edge is falling by default and rising when control bit 1 is set. Without frame sync the counter goes to 0 after reaching the frame-length field, or from any larger count.
- R3: A frame sync seen on a sampling edge loads the offset field into the counter. Frame sync is active low by default and active high when control bit 0 is set.
- R4: resync_o is high for exactly one cycle after a sampling edge with frame sync active, when the offset differs from the count the counter would otherwise have taken. It stays low when the sync is aligned.
- R5: With control bit 2 clear, slot_o = count/8 and slot_bit_o = count%8. With it set, count 0 is the framing bit: fbit_o is 1, no qualifier is set, slot and bit read 0 and the pin is driven from data. All other counts use count-1 in place of count.
- R6: Table word w is written at address 2+w. Slot s takes bits [2*(s%16)+1 : 2*(s%16)] of word s/16. Code 0 sets unass_o, code 1 hdlc_o, code 2 v56_o and code 3 v64_o. Slots at or beyond MAX_SLOTS are unassigned.
- R7: Table writes change the qualifiers only from the sampling edge on which the counter becomes 0. Before that edge the previous table stays in use.
- R8: In unassigned slots, control bits [4:3] set the pin: 0 forces tx low (tx_en_o=1, tx_force_o=1, tx_val_o=0), 1 forces it high (tx_val_o=1) and 2 or 3 floats it (tx_en_o=0).
- R9: In a 7-bit voice slot, the unused bit is slot bit 7 by default and slot bit 0 when control bit 7 is set. On that bit idle_bit_o is 1 and the pin follows control bits [6:5], with the same encoding as R8. Every other bit of a used slot, and the framing bit, gives tx_en_o=1, tx_force_o=0, tx_val_o=0.
- R10: Address 0 holds the frame offset in bits [31:16] and the frame-length field (frame bits minus one) in bits [15:0]. Address 1 holds the control byte in bits [7:0]. Both take effect immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | block clock, oversamples bclk_i |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | AW (2) | register address |
| wr_data_i | input | 32 | register write data |
| bclk_i | input | 1 | serial bit clock, synchronous to clk_i |
| fsync_i | input | 1 | frame sync |
| cnt_o | output | CNT_W | current bit count in the frame |
| resync_o | output | 1 | misaligned frame sync seen |
| fbit_o | output | 1 | current bit is the framing bit |
| slot_o | output | CNT_W-3 | current timeslot index |
| slot_bit_o | output | 3 | bit position in the timeslot |
| hdlc_o | output | 1 | bit belongs to a packetized slot |
| v56_o | output | 1 | bit belongs to a 7-bit voice slot |
| v64_o | output | 1 | bit belongs to an 8-bit voice slot |
| unass_o | output | 1 | bit belongs to an unassigned slot |
| idle_bit_o | output | 1 | unused bit of a 7-bit voice slot |
| tx_en_o | output | 1 | transmit pin driven |
| tx_force_o | output | 1 | pin driven with a constant, not data |
| tx_val_o | output | 1 | constant level when forced |

## Verification
The assertions assume that bclk_i is synchronous to clk_i and holds each level for at least one clock. This lets every edge be seen exactly once. The bench changes bclk_i and fsync_i only on the falling clock edge and never toggles bclk_i faster than that. Frame sync is sampled only on a sampling edge, so the bench sets its level together with the edge before the sampling edge. The bench keeps the offset no larger than the frame-length field. It also varies the length, the offset, the control byte and the table contents. The lengths it uses reach past the last table slot and down to a single slot.

// File: rtl/tdm_map_pkg.sv
package tdm_map_pkg;
  typedef enum logic [1:0] {
    CH_UNASS = 2'd0,
    CH_HDLC  = 2'd1,
    CH_V56   = 2'd2,
    CH_V64   = 2'd3
  } ch_type_e;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'd0,
    DRV_HIGH = 2'd1,
    DRV_HIZ  = 2'd2,
    DRV_HIZ2 = 2'd3
  } drv_mode_e;

  typedef struct packed {
    logic      v56_bit0;
    drv_mode_e v56_drv;
    drv_mode_e unass_drv;
    logic      fbit_en;
    logic      sample_rise;
    logic      fs_high;
  } ctrl_t;

  localparam int ADDR_FRAME = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_LUT0  = 2;
  localparam int LUT_PER_WORD = 16;
endpackage

// File: rtl/tdm_cfg_regs.sv
module tdm_cfg_regs
  import tdm_map_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_SLOTS = 32,
  parameter int AW        = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [31:0]            wr_data_i,
  input  logic                   apply_i,
  output logic [CNT_W-1:0]       offset_o,
  output logic [CNT_W-1:0]       size_m1_o,
  output ctrl_t                  ctrl_o,
  output logic [2*MAX_SLOTS-1:0] lut_act_o
);
  localparam int LUT_WORDS = MAX_SLOTS / LUT_PER_WORD;
  localparam logic [CNT_W-1:0] SIZE_RST = CNT_W'(MAX_SLOTS * 8 - 1);

  logic [2*MAX_SLOTS-1:0] lut_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      offset_o  <= '0;
      size_m1_o <= SIZE_RST;
      ctrl_o    <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(ADDR_FRAME)) begin
        offset_o  <= wr_data_i[16 +: CNT_W];
        size_m1_o <= wr_data_i[CNT_W-1:0];
      end
      if (wr_addr_i == AW'(ADDR_CTRL)) ctrl_o <= ctrl_t'(wr_data_i[7:0]);
    end
  end

  for (genvar w = 0; w < LUT_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lut_sh_q[32*w +: 32]  <= '0;
        lut_act_o[32*w +: 32] <= '0;
      end else begin
        if (wr_en_i && wr_addr_i == AW'(ADDR_LUT0 + w))
          lut_sh_q[32*w +: 32] <= wr_data_i;
        if (apply_i)
          lut_act_o[32*w +: 32] <= lut_sh_q[32*w +: 32];
      end
    end
  end

  assert_lut_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(lut_act_o));
endmodule

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bclk_i,
  input  logic             fsync_i,
  input  logic             fs_high_i,
  input  logic             sample_rise_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [CNT_W-1:0] size_m1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             resync_o,
  output logic             apply_o
);
  logic             bclk_q;
  logic             tick, fs_act;
  logic [CNT_W-1:0] succ, nxt;

  assign tick   = sample_rise_i ? (bclk_i & ~bclk_q) : (~bclk_i & bclk_q);
  assign fs_act = ~(fsync_i ^ fs_high_i);
  assign succ   = (cnt_o >= size_m1_i) ? '0 : cnt_o + 1'b1;
  assign nxt    = fs_act ? offset_i : succ;
  // frame boundary: the edge that takes the counter to 0
  assign apply_o = tick && (nxt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_q   <= 1'b0;
      cnt_o    <= '0;
      resync_o <= 1'b0;
    end else begin
      bclk_q   <= bclk_i;
      resync_o <= tick && fs_act && (offset_i != succ);
      if (tick) cnt_o <= nxt;
    end
  end

  assert_cnt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick |=> $stable(cnt_o));
  assert_cnt_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !fs_act && cnt_o >= size_m1_i) |=> (cnt_o == '0));
  assert_fs_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && fs_act) |=> (cnt_o == $past(offset_i)));
  assert_resync_src_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_o |-> $past(tick && fs_act));
endmodule

// File: rtl/tdm_slot_decode.sv
module tdm_slot_decode
  import tdm_map_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_SLOTS = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [CNT_W-1:0]       cnt_i,
  input  ctrl_t                  ctrl_i,
  input  logic [2*MAX_SLOTS-1:0] lut_i,
  output logic                   fbit_o,
  output logic [CNT_W-4:0]       slot_o,
  output logic [2:0]             slot_bit_o,
  output logic                   hdlc_o,
  output logic                   v56_o,
  output logic                   v64_o,
  output logic                   unass_o,
  output logic                   idle_bit_o,
  output logic                   tx_en_o,
  output logic                   tx_force_o,
  output logic                   tx_val_o
);
  localparam int SW = $clog2(MAX_SLOTS);
  localparam int PW = CNT_W - 3;

  logic [CNT_W-1:0] pos;
  logic [PW-1:0]    slot;
  logic             in_range;
  ch_type_e         ty;
  drv_mode_e        mode;
  logic             forced;

  always_comb begin
    fbit_o = ctrl_i.fbit_en && (cnt_i == '0);
    pos    = fbit_o ? '0 : cnt_i - CNT_W'(ctrl_i.fbit_en);
    slot   = pos[CNT_W-1:3];
    slot_o = slot;
    slot_bit_o = pos[2:0];
    in_range = slot < PW'(MAX_SLOTS);
    ty = CH_UNASS;
    if (in_range) ty = ch_type_e'(lut_i[{slot[SW-1:0], 1'b0} +: 2]);
    hdlc_o  = !fbit_o && ty == CH_HDLC;
    v56_o   = !fbit_o && ty == CH_V56;
    v64_o   = !fbit_o && ty == CH_V64;
    unass_o = !fbit_o && ty == CH_UNASS;
    idle_bit_o = v56_o && (slot_bit_o == (ctrl_i.v56_bit0 ? 3'd0 : 3'd7));
    forced = unass_o || idle_bit_o;
    mode   = unass_o ? ctrl_i.unass_drv : ctrl_i.v56_drv;
    tx_en_o    = !(forced && mode[1]);
    tx_force_o = forced && !mode[1];
    tx_val_o   = forced && (mode == DRV_HIGH);
  end

  assert_one_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fbit_o, hdlc_o, v56_o, v64_o, unass_o}));
  assert_float_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> (unass_o || idle_bit_o));
  assert_idle_in56_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_bit_o |-> (v56_o && !tx_val_o || v56_o));
  assert_fbit_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fbit_o |-> (tx_en_o && !tx_force_o));
endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
  import tdm_map_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MAX_SLOTS = 32,
  localparam int AW = $clog2(MAX_SLOTS / LUT_PER_WORD + ADDR_LUT0)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [31:0]      wr_data_i,
  input  logic             bclk_i,
  input  logic             fsync_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             resync_o,
  output logic             fbit_o,
  output logic [CNT_W-4:0] slot_o,
  output logic [2:0]       slot_bit_o,
  output logic             hdlc_o,
  output logic             v56_o,
  output logic             v64_o,
  output logic             unass_o,
  output logic             idle_bit_o,
  output logic             tx_en_o,
  output logic             tx_force_o,
  output logic             tx_val_o
);
  logic [CNT_W-1:0]       offset, size_m1;
  ctrl_t                  ctrl;
  logic [2*MAX_SLOTS-1:0] lut_act;
  logic                   apply;

  tdm_cfg_regs #(.CNT_W(CNT_W), .MAX_SLOTS(MAX_SLOTS), .AW(AW)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .apply_i(apply), .offset_o(offset), .size_m1_o(size_m1),
    .ctrl_o(ctrl), .lut_act_o(lut_act)
  );

  tdm_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .bclk_i, .fsync_i,
    .fs_high_i(ctrl.fs_high), .sample_rise_i(ctrl.sample_rise),
    .offset_i(offset), .size_m1_i(size_m1),
    .cnt_o, .resync_o, .apply_o(apply)
  );

  tdm_slot_decode #(.CNT_W(CNT_W), .MAX_SLOTS(MAX_SLOTS)) u_dec (
    .clk_i, .rst_ni, .cnt_i(cnt_o), .ctrl_i(ctrl), .lut_i(lut_act),
    .fbit_o, .slot_o, .slot_bit_o, .hdlc_o, .v56_o, .v64_o, .unass_o,
    .idle_bit_o, .tx_en_o, .tx_force_o, .tx_val_o
  );
endmodule

// File: tb/sim_tdm_slot_mapper.sv
module sim_tdm_slot_mapper;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        bclk = 1'b1;
  logic        fsync = 1'b1;
  logic [15:0] cnt;
  logic        resync, fbit, hdlc, v56, v64, unass, idle, tx_en, tx_force, tx_val;
  logic [12:0] slot;
  logic [2:0]  sbit;

  always #10 clk = ~clk;

  tdm_slot_mapper u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .bclk_i(bclk), .fsync_i(fsync), .cnt_o(cnt), .resync_o(resync), .fbit_o(fbit),
    .slot_o(slot), .slot_bit_o(sbit), .hdlc_o(hdlc), .v56_o(v56), .v64_o(v64),
    .unass_o(unass), .idle_bit_o(idle), .tx_en_o(tx_en), .tx_force_o(tx_force),
    .tx_val_o(tx_val)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_cnt = 0, m_off = 0, m_size = 16'd255;
  logic [7:0]  m_ctrl = 0;
  logic [63:0] m_sh = 0, m_act = 0;
  logic        m_rs = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_out();
    logic fb, h, a, b, un, id, en, fo, vl;
    logic [15:0] p;
    logic [12:0] s;
    logic [2:0] sb;
    logic [1:0] ty, md;
    fb = m_ctrl[2] && m_cnt == 0;
    p  = fb ? 16'd0 : m_cnt - {15'd0, m_ctrl[2]};
    s  = p[15:3];
    sb = p[2:0];
    ty = (s < 13'd32) ? 2'((m_act >> (32'(s) * 2)) & 64'd3) : 2'd0;
    h  = !fb && ty == 2'd1;
    a  = !fb && ty == 2'd2;
    b  = !fb && ty == 2'd3;
    un = !fb && ty == 2'd0;
    id = a && (sb == (m_ctrl[7] ? 3'd0 : 3'd7));
    md = un ? m_ctrl[4:3] : m_ctrl[6:5];
    en = !((un || id) && md[1]);
    fo = (un || id) && !md[1];
    vl = (un || id) && md == 2'd1;
    return {7'd0, fb, h, a, b, un, id, en, fo, vl, s, sb};
  endfunction

  function automatic logic [31:0] act_out();
    return {7'd0, fbit, hdlc, v56, v64, unass, idle, tx_en, tx_force, tx_val, slot, sbit};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      2'd0: begin m_off = d[31:16]; m_size = d[15:0]; end
      2'd1: m_ctrl = d[7:0];
      2'd2: m_sh[31:0] = d;
      default: m_sh[63:32] = d;
    endcase
  endtask

  task automatic step(input bit fs, input string tag);
    logic pre;
    logic [15:0] succ, nxt;
    pre = m_ctrl[1] ? 1'b0 : 1'b1;
    @(negedge clk);
    bclk = pre; fsync = m_ctrl[0] ? fs : ~fs;
    @(negedge clk);
    bclk = ~pre;
    @(negedge clk);
    succ = (m_cnt >= m_size) ? 16'd0 : m_cnt + 16'd1;
    nxt  = fs ? m_off : succ;
    m_rs = fs && (m_off != succ);
    if (nxt == 0) m_act = m_sh;
    m_cnt = nxt;
    check({tag, " count"}, 32'(cnt), 32'(m_cnt));
    check({tag, " resync R4"}, 32'(resync), 32'(m_rs));
    check({tag, " decode"}, act_out(), exp_out());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 count", 32'(cnt), 32'd0);
    check("R1 decode", act_out(), exp_out());
    check("R1 resync", 32'(resync), 32'd0);

    // R10: 40-bit frame, count wraps after 39
    wr(2'd0, {16'd0, 16'd39});
    for (int i = 0; i < 50; i++) step(0, "R10");

    // R7: table write waits for boundary
    wr(2'd2, 32'hE4E4_E4E4);
    while (m_cnt != 16'd39) step(0, "R7");
    check("R7 old table kept", 32'(unass), 32'd1);
    step(0, "R7");
    for (int i = 0; i < 40; i++) step(0, "R6");

    // R2: rising edge sampling
    wr(2'd1, 32'h02);
    for (int i = 0; i < 20; i++) step(0, "R2");

    // R3/R4: active-high sync, offset 5, misaligned and aligned
    wr(2'd1, 32'h01);
    wr(2'd0, {16'd5, 16'd39});
    for (int i = 0; i < 7; i++) step(0, "R3");
    step(1, "R3");
    check("R3 loaded offset", 32'(cnt), 32'd5);
    check("R4 misaligned", 32'(resync), 32'd1);
    step(0, "R4");
    check("R4 one cycle", 32'(resync), 32'd0);
    while (m_cnt != 16'd4) step(0, "R4");
    step(1, "R4");
    check("R4 aligned no flag", 32'(resync), 32'd0);

    // R5: framing bit, 41-bit frame
    wr(2'd1, 32'h04);
    wr(2'd0, {16'd0, 16'd40});
    for (int i = 0; i < 90; i++) step(0, "R5");

    // R8: unassigned high, then floating
    wr(2'd2, 32'h0000_0000);
    wr(2'd1, 32'h08);
    for (int i = 0; i < 45; i++) step(0, "R8");
    wr(2'd1, 32'h10);
    for (int i = 0; i < 45; i++) step(0, "R8");

    // R9: all 7-bit voice, unused bit drive and position
    wr(2'd2, 32'hAAAA_AAAA);
    wr(2'd1, 32'h20);
    for (int i = 0; i < 90; i++) step(0, "R9");
    wr(2'd1, 32'hC0);
    for (int i = 0; i < 45; i++) step(0, "R9");

    // R6 random mix, frames longer than the table and very short
    for (int r = 0; r < 40; r++) begin
      logic [15:0] sz;
      sz = 16'(7 + $urandom % 300);
      if (r % 9 == 4) sz = 16'd7;
      wr(2'd0, {16'($urandom % (32'(sz) + 1)), sz});
      wr(2'd1, 32'($urandom & 32'hFF));
      wr(2'd2, $urandom);
      wr(2'd3, $urandom);
      for (int i = 0; i < 60; i++) step(($urandom % 25) == 0, "R6");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule